// File: doc/BRIEF.md
# Multi-CPU Interrupt Distributor

This block collects a vector of level-sensitive interrupt sources and presents them to up to four CPUs. Every source has a global enable bit and a routing word that lists the CPUs allowed to see it. Each CPU also keeps a private mask over all sources. A source is eligible for a CPU when its line is high, the CPU has not masked it, the source is enabled, and its routing word selects that CPU. One dedicated timer source is handled per CPU. It ignores the enable and routing state and is gated only by each CPU's private mask.

Software uses a simple register bus. Every access carries the index of the CPU that issues it. Enable and mask bits are never written as bitmaps. Software writes a source number to a set address or a clear address. The acknowledge register returns the lowest-numbered source that is eligible for the reading CPU. Reading it has no side effect, and because all sources are level-sensitive, an interrupt stays visible until its line falls. Each CPU has one interrupt output. It is high whenever at least one source is eligible for that CPU. Nothing stops two CPUs from claiming the same source, so routing one source to several CPUs is allowed but left to software to coordinate.

Top module: `irq_distributor`

## Requirements
- R1: After reset, all global enables are clear, every CPU mask bit is set and every routing word reads 0. As a result, every interrupt output is low and every acknowledge read returns 1023.
- R2: A write of a source number to address 0x30 sets that source's global enable.
- R3: A write of a source number to address 0x34 clears that source's global enable.
- R4: A write of a source number to address 0x48 masks that source for the issuing CPU only.
- R5: A write of a source number to address 0x4C unmasks that source for the issuing CPU only.
- R6: The routing word of source i is at address 0x100 + 4*i. Bit c of the word (bits [NUM_CPUS-1:0]) routes the source to CPU c. The word reads back with its other bits as 0.
- R7: A read of address 0x44 returns, in bits [9:0], the lowest-numbered source eligible for the reading CPU. It returns 1023 when no source is eligible.
- R8: A read of address 0x00 returns the number of implemented sources in bits [11:2], with all other bits 0.
- R9: Source TIMER_SRC (default 5) is eligible for a CPU whenever its line is high and that CPU has it unmasked, regardless of its enable bit and its routing word.
- R10: Interrupt output c is high exactly when some source is eligible for CPU c.
- R11: A source routed to several CPUs is eligible for each of them at the same time.
- R12: An enable or mask write that carries a value of NUM_SRC or more changes no state.
- R13: Sources are level-sensitive. When a source line falls, it stops being eligible in the same cycle, without any acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the current access |
| bus_cpu | input | CPU_W | Index of the CPU issuing the access |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr as seen by bus_cpu (combinational) |
| irq_src | input | NUM_SRC | Level-sensitive source lines |
| cpu_irq | output | NUM_CPUS | One interrupt output per CPU |

## Verification
The bench uses the default build: four CPUs, 32 sources and the timer at source 5. With these values the highest CPU index and a full five-bit source number are both exercised. The bench also writes the values 32 to 39 and 41, which would alias onto real sources if the range check only looked at the low bits. Directed steps cover the timer bypass, the lowest-index choice, the masking of one CPU versus another, and a source routed to two CPUs. Several hundred random enable, mask, routing and line operations follow, each one compared against a bench model of every CPU's acknowledge value and output.

// File: rtl/irq_dist_pkg.sv
// Package: shared bus widths and register addresses of the interrupt distributor.
// Assumes a byte-addressed 12-bit register space with 32-bit data.
package irq_dist_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int ID_W   = 10;

    localparam logic [ADDR_W-1:0] A_CTRL       = 12'h000;
    localparam logic [ADDR_W-1:0] A_EN_SET     = 12'h030;
    localparam logic [ADDR_W-1:0] A_EN_CLR     = 12'h034;
    localparam logic [ADDR_W-1:0] A_ACK        = 12'h044;
    localparam logic [ADDR_W-1:0] A_MSK_SET    = 12'h048;
    localparam logic [ADDR_W-1:0] A_MSK_CLR    = 12'h04C;
    localparam logic [ADDR_W-1:0] A_ROUTE_BASE = 12'h100;

    localparam logic [ID_W-1:0] ID_NONE = '1;
endpackage

// File: rtl/irq_src_regs.sv
// Module: per-source global enable bits and CPU routing words.
// Assumes one access per cycle. Enable writes carry a source number, and a
// number out of range is ignored.
module irq_src_regs
    import irq_dist_pkg::*;
#(
    parameter int NUM_SRC  = 32,
    parameter int NUM_CPUS = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr,
    input  logic [ADDR_W-1:0]                  addr,
    input  logic [DATA_W-1:0]                  wdata,
    output logic [NUM_SRC-1:0]                 en,
    output logic [NUM_SRC-1:0][NUM_CPUS-1:0]   route
);
    localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic              idx_ok;
    logic [SRC_W-1:0]  idx;
    logic [ADDR_W-1:0] rt_off;
    logic              rt_hit;
    logic [SRC_W-1:0]  rt_idx;

    // Decode the source number and the routing word address.
    assign idx_ok = wdata < DATA_W'(NUM_SRC);
    assign idx    = wdata[SRC_W-1:0];
    assign rt_off = addr - A_ROUTE_BASE;
    assign rt_hit = (addr >= A_ROUTE_BASE) && (rt_off[1:0] == 2'b00)
                    && (rt_off[ADDR_W-1:2] < (ADDR_W-2)'(NUM_SRC));
    assign rt_idx = rt_off[SRC_W+1:2];

    // Global enable bits, set or cleared by source number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= '0;
        end else if (wr && idx_ok) begin
            if (addr == A_EN_SET)      en[idx] <= 1'b1;
            else if (addr == A_EN_CLR) en[idx] <= 1'b0;
        end
    end

    // Routing words, one CPU bitmap per source.
    always_ff @(posedge clk) begin
        if (!rst_n)             route <= '0;
        else if (wr && rt_hit)  route[rt_idx] <= wdata[NUM_CPUS-1:0];
    end

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (en == '0 && route == '0));
    assert_enable_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_EN_SET && idx_ok) |=> en[$past(idx)]);
    assert_enable_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_EN_CLR && idx_ok) |=> !en[$past(idx)]);
    assert_range_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !idx_ok && !rt_hit) |=> $stable(en) && $stable(route));
endmodule

// File: rtl/irq_cpu_mask.sv
// Module: the private mask of one CPU. A set bit blocks that source.
// Assumes wr is already qualified with the issuing CPU's index.
module irq_cpu_mask
    import irq_dist_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [NUM_SRC-1:0]  mask
);
    localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic             idx_ok;
    logic [SRC_W-1:0] idx;

    // Decode the source number carried by the write.
    assign idx_ok = wdata < DATA_W'(NUM_SRC);
    assign idx    = wdata[SRC_W-1:0];

    // Mask bits: set masks, clear unmasks. Reset masks everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '1;
        end else if (wr && idx_ok) begin
            if (addr == A_MSK_SET)      mask[idx] <= 1'b1;
            else if (addr == A_MSK_CLR) mask[idx] <= 1'b0;
        end
    end

    assert_mask_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_MSK_SET && idx_ok) |=> mask[$past(idx)]);
    assert_mask_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_MSK_CLR && idx_ok) |=> !mask[$past(idx)]);
    assert_no_write_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(mask));
endmodule

// File: rtl/irq_pick.sv
// Module: fixed-priority encoder. It returns the lowest set index, or the
// no-source code when no bit is set.
// Assumes NUM_SRC is below the no-source code (1023).
module irq_pick
    import irq_dist_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic [NUM_SRC-1:0] elig,
    output logic [ID_W-1:0]    id,
    output logic               any
);
    // Scan from the top so that the lowest eligible index wins.
    always_comb begin
        id = ID_NONE;
        for (int s = NUM_SRC - 1; s >= 0; s--) begin
            if (elig[s]) id = ID_W'(s);
        end
    end

    // Flag when any source is eligible.
    assign any = |elig;
endmodule

// File: rtl/irq_distributor.sv
// Module: top of the level-sensitive interrupt distributor for several CPUs.
// Assumes each bus access identifies its CPU in bus_cpu. Reads are
// combinational and have no side effect.
module irq_distributor
    import irq_dist_pkg::*;
#(
    parameter int NUM_CPUS  = 4,
    parameter int NUM_SRC   = 32,
    parameter int TIMER_SRC = 5,
    localparam int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [CPU_W-1:0]    bus_cpu,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_SRC-1:0]  irq_src,
    output logic [NUM_CPUS-1:0] cpu_irq
);
    localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [NUM_SRC-1:0]               en;
    logic [NUM_SRC-1:0][NUM_CPUS-1:0] route;
    logic [NUM_CPUS-1:0][NUM_SRC-1:0] mask;
    logic [NUM_CPUS-1:0][NUM_SRC-1:0] elig;
    logic [NUM_CPUS-1:0][ID_W-1:0]    ack_id;
    logic [ADDR_W-1:0]                rd_off;
    logic                             rd_route;

    irq_src_regs #(.NUM_SRC(NUM_SRC), .NUM_CPUS(NUM_CPUS)) i_src_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .en(en), .route(route)
    );

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        irq_cpu_mask #(.NUM_SRC(NUM_SRC)) i_mask (
            .clk(clk), .rst_n(rst_n),
            .wr(bus_wr && (bus_cpu == CPU_W'(c))),
            .addr(bus_addr), .wdata(bus_wdata), .mask(mask[c])
        );

        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            if (s == TIMER_SRC) begin : g_timer
                // The timer is gated only by this CPU's private mask.
                assign elig[c][s] = irq_src[s] && !mask[c][s];
            end else begin : g_shared
                // Shared sources need the enable bit and a route to this CPU.
                assign elig[c][s] = irq_src[s] && !mask[c][s] && en[s] && route[s][c];
            end
        end

        irq_pick #(.NUM_SRC(NUM_SRC)) i_pick (
            .elig(elig[c]), .id(ack_id[c]), .any(cpu_irq[c])
        );

        assert_ack_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_irq[c] |-> (ack_id[c] < ID_W'(NUM_SRC)) && irq_src[ack_id[c][SRC_W-1:0]]
                           && !mask[c][ack_id[c][SRC_W-1:0]]);
        assert_idle_none_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !cpu_irq[c] |-> (ack_id[c] == ID_NONE));
        assert_level_drop_R13: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_src == '0) |-> !cpu_irq[c]);
    end

    // Decode a read of a routing word.
    assign rd_off   = bus_addr - A_ROUTE_BASE;
    assign rd_route = (bus_addr >= A_ROUTE_BASE) && (rd_off[1:0] == 2'b00)
                      && (rd_off[ADDR_W-1:2] < (ADDR_W-2)'(NUM_SRC));

    // Read data: control word, the issuing CPU's acknowledge value, or a routing word.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL) begin
            bus_rdata[11:2] = 10'(NUM_SRC);
        end else if (bus_addr == A_ACK) begin
            bus_rdata[ID_W-1:0] = ack_id[bus_cpu];
        end else if (rd_route) begin
            bus_rdata[NUM_CPUS-1:0] = route[rd_off[SRC_W+1:2]];
        end
    end
endmodule

// File: tb/test_irq_distributor.sv
module test_irq_distributor;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NC = 4;
    localparam int NS = 32;
    localparam int TS = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_cpu = '0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NS-1:0] irq_src = '0;
    logic [NC-1:0] cpu_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    bit m_en [NS];
    bit m_msk [NC][NS];
    logic [NC-1:0] m_rt [NS];

    irq_distributor #(.NUM_CPUS(NC), .NUM_SRC(NS), .TIMER_SRC(TS)) i_irq_distributor (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_cpu(bus_cpu),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_src(irq_src), .cpu_irq(cpu_irq)
    );

    always #5 clk = ~clk;

    function automatic bit elig(int c, int s);
        if (!irq_src[s] || m_msk[c][s]) return 0;
        if (s == TS) return 1;
        return m_en[s] && m_rt[s][c];
    endfunction

    function automatic int exp_ack(int c);
        for (int s = 0; s < NS; s++) if (elig(c, s)) return s;
        return 1023;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < NS; s++) begin
            m_en[s] = 0;
            m_rt[s] = '0;
            for (int c = 0; c < NC; c++) m_msk[c][s] = 1;
        end
    endtask

    task automatic bus_write(int cpu, logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_cpu = 2'(cpu); bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        if (d < NS) begin
            case (a)
                12'h030: m_en[d] = 1;
                12'h034: m_en[d] = 0;
                12'h048: m_msk[cpu][d] = 1;
                12'h04C: m_msk[cpu][d] = 0;
                default: ;
            endcase
        end
        if (a >= 12'h100 && a < 12'h100 + 4*NS && a[1:0] == 2'b00)
            m_rt[(a - 12'h100) >> 2] = d[NC-1:0];
    endtask

    task automatic bus_read(int cpu, logic [11:0] a, output logic [31:0] d);
        bus_cpu = 2'(cpu); bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic check_all(string req);
        logic [31:0] d;
        logic [NC-1:0] exp_vec;
        for (int c = 0; c < NC; c++) begin
            bus_read(c, 12'h044, d);
            chk(d == 32'(exp_ack(c)), req, int'(d), exp_ack(c));
            exp_vec[c] = (exp_ack(c) != 1023);
        end
        chk(cpu_irq == exp_vec, req, int'(cpu_irq), int'(exp_vec));
    endtask

    // watchdog
    initial begin
        #2_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(negedge clk);
        irq_src = '1;
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_all("R1");
        bus_read(0, 12'h10C, d);
        chk(d == 0, "R1 route", int'(d), 0);
        // R8 control word
        bus_read(1, 12'h000, d);
        chk(d == (NS << 2), "R8", int'(d), NS << 2);

        // R9 timer bypasses enable and routing
        bus_write(2, 12'h04C, TS);
        check_all("R9");
        chk(cpu_irq == 4'b0100, "R9 out", int'(cpu_irq), 4);

        // R2 R6 enable + route source 9 to CPU1
        bus_write(0, 12'h030, 9);
        bus_write(0, 12'h124, 32'hFFFF_FFF2);
        bus_write(1, 12'h04C, 9);
        check_all("R2 R6");
        bus_read(3, 12'h124, d);
        chk(d == 2, "R6 readback", int'(d), 2);

        // R5 R7 lower source wins on CPU1
        bus_write(1, 12'h04C, 3);
        bus_write(1, 12'h030, 3);
        bus_write(1, 12'h10C, 2);
        bus_read(1, 12'h044, d);
        chk(d == 3, "R7 lowest", int'(d), 3);

        // R4 mask by another CPU leaves CPU1 unaffected, then its own mask
        bus_write(0, 12'h048, 3);
        bus_read(1, 12'h044, d);
        chk(d == 3, "R4 other cpu", int'(d), 3);
        bus_write(1, 12'h048, 3);
        bus_read(1, 12'h044, d);
        chk(d == 9, "R4 own cpu", int'(d), 9);

        // R3 R10 clear enable leaves CPU1 with nothing
        bus_write(2, 12'h034, 9);
        check_all("R3 R10");
        chk(cpu_irq[1] == 1'b0, "R10 idle", int'(cpu_irq[1]), 0);

        // R12 out-of-range values alias nothing
        bus_write(1, 12'h030, 41);
        bus_write(1, 12'h04C, 35);
        bus_write(2, 12'h048, 37);
        check_all("R12");
        bus_read(1, 12'h044, d);
        chk(d == 1023, "R12 alias", int'(d), 1023);

        // R11 one source routed to two CPUs
        bus_write(0, 12'h150, 9);
        bus_write(0, 12'h030, 20);
        bus_write(0, 12'h04C, 20);
        bus_write(3, 12'h04C, 20);
        check_all("R11");
        chk(cpu_irq[0] && cpu_irq[3], "R11 both", int'(cpu_irq), 9);

        // R13 level drop removes it at once
        irq_src[20] = 1'b0;
        #1;
        chk(!cpu_irq[0] && !cpu_irq[3], "R13", int'(cpu_irq), 4);
        check_all("R13");

        // random phase
        for (int i = 0; i < 400; i++) begin
            int op  = $urandom_range(0, 5);
            int cpu = $urandom_range(0, NC-1);
            int idx = $urandom_range(0, 39);
            case (op)
                0: bus_write(cpu, 12'h030, idx);
                1: bus_write(cpu, 12'h034, idx);
                2: bus_write(cpu, 12'h048, idx);
                3: bus_write(cpu, 12'h04C, idx);
                4: bus_write(cpu, 12'(12'h100 + 4*(idx % NS)), $urandom);
                default: begin
                    @(negedge clk);
                    irq_src = $urandom;
                end
            endcase
            check_all("R7 R10 random");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule